// File: doc/BRIEF.md
# Dual-Mode Timer with Time Base

This block is an 8-bit up-counter fed by one of two prescaler chains. In interval mode it counts taps of a prescaler that runs on the system clock. In time-base mode it counts taps of a second prescaler that advances on each rising edge of a slow subclock. The subclock is asynchronous to the system clock, so it is resynchronised first. A rollover from all-ones to zero sets a sticky interrupt flag.

One control register sets the counting mode, the tap and a clear strobe for time-base use, and a selector for a divided-clock output pin. The power-mode input decides three things: whether each counting mode runs or halts, whether the control register accepts writes, and which clock-output sources may toggle the pin. Software clears the flag by writing 0 to it.

Top module: `tbase_timer`

## Requirements
- R1: While `rst` is high, or while `pmode` is 0 (reset state), the count, the control register, the flag and `clk_out` are all 0.
- R2: With control bit 3 at 0 (interval mode), let s be control bits [2:0]. The count then rises by exactly one for every 2^(s+1) system clocks.
- R3: With control bit 3 at 1 (time-base mode), control bits [1:0] of 00, 01, 10 and 11 give one increment per 128, 64, 32 and 4 subclock rising edges.
- R4: A control write in which bits 3 and 2 are both 1 sets the count and the subclock prescaler to zero.
- R5: A count rollover from 255 to 0 sets `irq`. The flag then stays set until a flag write with data 0. A flag write with data 1 has no effect.
- R6: Power-mode codes are 0 reset, 1 active, 2 sleep, 3 watch, 4 subactive, 5 subsleep and 6 standby. Interval mode counts only in active and sleep, and halts in every other mode.
- R7: Time-base mode counts in every mode except reset and standby.
- R8: Control writes take effect only in active and subactive modes. In every other mode they are ignored.
- R9: `clk_out` is 0 while `clkout_en` is 0. With `clkout_raw` at 1, the pin follows the synchronised subclock. Otherwise control bit 7 picks the source (0 system prescaler, 1 subclock prescaler), and bits [6:5] of 00, 01, 10 and 11 divide that source by 32, 16, 8 and 4.
- R10: System-clock sources hold `clk_out` low outside active and sleep. Divided subclock sources hold it low in reset and standby. The raw subclock holds it low only in reset.
- R11: The subclock passes through a two-flop synchroniser and a rising-edge detector. Each subclock rising edge gives exactly one single-cycle advance pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_clk | input | 1 | Asynchronous slow subclock |
| pmode | input | 3 | Power-mode code |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| irq_wr | input | 1 | Interrupt flag write strobe |
| irq_wdata | input | 1 | Interrupt flag write data (0 clears) |
| clkout_en | input | 1 | Clock-output pin enable |
| clkout_raw | input | 1 | Selects the undivided subclock for the pin |
| irq | output | 1 | Sticky overflow interrupt flag |
| count | output | 8 | Current counter value |
| clk_out | output | 1 | Divided-clock output pin |

## Verification
The assertions check these rules on every cycle:
- The count only ever steps by one or returns to zero.
- The count stays frozen in the power modes where its current mode halts.
- The control register holds its value outside the writable modes.
- The flag stays set until a write of 0.
- The synchroniser never emits two pulses in a row.
- The pin stays low when its source is gated off.

Only the bench scenarios can show the exact rates. These are the increments per window for every interval tap and every time-base period, the prescaler reset done by the clear strobe, and the pin's toggle count per window for each divider source.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

  typedef enum logic [2:0] {
    PM_RESET   = 3'd0,
    PM_ACTIVE  = 3'd1,
    PM_SLEEP   = 3'd2,
    PM_WATCH   = 3'd3,
    PM_SUBACT  = 3'd4,
    PM_SUBSLP  = 3'd5,
    PM_STANDBY = 3'd6
  } pmode_e;

  typedef struct packed {
    logic       out_sub;   // bit 7: clock-output source family
    logic [1:0] out_div;   // bits 6:5: divider pick
    logic       rsvd;      // bit 4
    logic       tbase;     // bit 3: time-base mode
    logic       sel_hi;    // bit 2: interval tap MSB / clear strobe
    logic [1:0] per;       // bits 1:0: tap / period
  } ctrl_t;

  function automatic logic sys_runs(pmode_e pm);
    return (pm == PM_ACTIVE) || (pm == PM_SLEEP);
  endfunction

  function automatic logic tb_runs(pmode_e pm);
    return (pm != PM_RESET) && (pm != PM_STANDBY) && (pm != pmode_e'(3'd7));
  endfunction

  function automatic logic ctrl_writable(pmode_e pm);
    return (pm == PM_ACTIVE) || (pm == PM_SUBACT);
  endfunction

  function automatic logic subdiv_out_ok(pmode_e pm);
    return (pm == PM_ACTIVE) || (pm == PM_SLEEP) || (pm == PM_WATCH) ||
           (pm == PM_SUBACT) || (pm == PM_SUBSLP);
  endfunction

endpackage

// File: rtl/tbt_sync.sv
module tbt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~prev_q;

  // R11: one edge never yields back-to-back pulses
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/tbt_prescaler.sv
module tbt_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (clr)     q <= '0;
    else if (en) q <= q + W'(1);
  end
endmodule

// File: rtl/tbt_clkout.sv
module tbt_clkout
  import tbt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pmode_e     pm,
  input  logic       en,
  input  logic       raw_sel,
  input  logic       use_sub,
  input  logic [1:0] div_sel,
  input  logic [3:0] sys_taps,   // [0] = /4 ... [3] = /32
  input  logic [3:0] sub_taps,
  input  logic       sub_lvl,
  output logic       pin
);
  logic [1:0] tap_idx;
  logic       src, ok, pin_q;

  always_comb begin
    tap_idx = ~div_sel;
    if (raw_sel) begin
      src = sub_lvl;
      ok  = (pm != PM_RESET);
    end else if (use_sub) begin
      src = sub_taps[tap_idx];
      ok  = subdiv_out_ok(pm);
    end else begin
      src = sys_taps[tap_idx];
      ok  = sys_runs(pm);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= en & ok & src;
  end

  assign pin = pin_q;

  // R10: system sources gated off outside active/sleep
  assert_sys_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (!raw_sel && !use_sub && !sys_runs(pm)) |=> !pin);

  // R9: disabled pin stays low
  assert_pin_off_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pin);

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYS_PS_W    = 8,
  parameter int SUB_PS_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sub_clk,
  input  logic [2:0]       pmode,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             irq_wr,
  input  logic             irq_wdata,
  input  logic             clkout_en,
  input  logic             clkout_raw,
  output logic             irq,
  output logic [CNT_W-1:0] count,
  output logic             clk_out
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  pmode_e pm;
  logic   hard_clr, wr_ok, tb_clear;
  logic   sub_lvl, sub_rise;
  ctrl_t  ctrl_q;
  logic [SYS_PS_W-1:0] sys_q, iv_mask;
  logic [SUB_PS_W-1:0] sub_q, tb_mask;
  logic [2:0]          iv_sel;
  int                  tb_shift;
  logic                tick_iv, tick_tb, tick, ovf;
  logic [CNT_W-1:0]    cnt_q;
  logic                irq_q;

  assign pm       = pmode_e'(pmode);
  assign hard_clr = rst | (pm == PM_RESET);
  assign wr_ok    = wr_en & ctrl_writable(pm);
  assign tb_clear = wr_ok & wr_data[3] & wr_data[2];

  tbt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(hard_clr), .async_in(sub_clk),
    .level(sub_lvl), .rise(sub_rise));

  tbt_prescaler #(.W(SYS_PS_W)) u_sys_ps (
    .clk(clk), .clr(hard_clr), .en(sys_runs(pm)), .q(sys_q));

  tbt_prescaler #(.W(SUB_PS_W)) u_sub_ps (
    .clk(clk), .clr(hard_clr | tb_clear), .en(sub_rise), .q(sub_q));

  always_ff @(posedge clk) begin
    if (hard_clr)   ctrl_q <= '0;
    else if (wr_ok) ctrl_q <= ctrl_t'(wr_data);
  end

  assign iv_sel = {ctrl_q.sel_hi, ctrl_q.per};

  always_comb begin
    case (ctrl_q.per)
      2'd0:    tb_shift = 7;
      2'd1:    tb_shift = 6;
      2'd2:    tb_shift = 5;
      default: tb_shift = 2;
    endcase
    iv_mask = '0;
    for (int i = 0; i < SYS_PS_W; i++)
      if (i <= int'(iv_sel)) iv_mask[i] = 1'b1;
    tb_mask = '0;
    for (int i = 0; i < SUB_PS_W; i++)
      if (i < tb_shift) tb_mask[i] = 1'b1;
  end

  assign tick_iv = !ctrl_q.tbase & sys_runs(pm) & ((sys_q & iv_mask) == iv_mask);
  assign tick_tb = ctrl_q.tbase & tb_runs(pm) & sub_rise & ((sub_q & tb_mask) == tb_mask);
  assign tick    = tick_iv | tick_tb;
  assign ovf     = tick & (cnt_q == CNT_TOP) & !tb_clear;

  always_ff @(posedge clk) begin
    if (hard_clr | tb_clear) cnt_q <= '0;
    else if (tick)           cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (hard_clr)                 irq_q <= 1'b0;
    else if (ovf)                 irq_q <= 1'b1;
    else if (irq_wr & !irq_wdata) irq_q <= 1'b0;
  end

  tbt_clkout u_clkout (
    .clk(clk), .rst(hard_clr), .pm(pm), .en(clkout_en), .raw_sel(clkout_raw),
    .use_sub(ctrl_q.out_sub), .div_sel(ctrl_q.out_div),
    .sys_taps(sys_q[4:1]), .sub_taps(sub_q[4:1]), .sub_lvl(sub_lvl),
    .pin(clk_out));

  assign count = cnt_q;
  assign irq   = irq_q;

  // R2: count moves by one step or returns to zero
  assert_count_step_R2: assert property (@(posedge clk) disable iff (hard_clr)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == '0));

  // R6: interval count frozen in halting modes
  assert_iv_halt_R6: assert property (@(posedge clk) disable iff (hard_clr)
    (!ctrl_q.tbase && !sys_runs(pm) && !wr_en) |=> $stable(cnt_q));

  // R7: standby freezes the count
  assert_standby_halt_R7: assert property (@(posedge clk) disable iff (hard_clr)
    (pm == PM_STANDBY) |=> $stable(cnt_q));

  // R8: control register only changes through a permitted write
  assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (hard_clr)
    (!(wr_en && ctrl_writable(pm)) && pmode != 3'd0) |=> $stable(ctrl_q));

  // R5: flag is sticky until a clearing write
  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (hard_clr)
    (irq_q && !(irq_wr && !irq_wdata) && pmode != 3'd0 && !rst) |=> irq_q);

endmodule

// File: tb/tb_tbase_timer.sv
`timescale 1ns/1ps
module tb_tbase_timer;
  localparam logic [2:0] P_RST = 3'd0, P_ACT = 3'd1, P_SLP = 3'd2, P_WCH = 3'd3,
                         P_SUBA = 3'd4, P_SUBS = 3'd5, P_STBY = 3'd6;

  logic clk = 1'b0, rst = 1'b1, sub_clk = 1'b0;
  logic [2:0] pmode = P_ACT;
  logic wr_en = 1'b0, irq_wr = 1'b0, irq_wdata = 1'b0;
  logic [7:0] wr_data = '0;
  logic clkout_en = 1'b0, clkout_raw = 1'b0;
  logic irq, clk_out;
  logic [7:0] count;

  int nchk = 0, nfail = 0, rises = 0;
  logic pin_d = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tbase_timer dut (
    .clk(clk), .rst(rst), .sub_clk(sub_clk), .pmode(pmode),
    .wr_en(wr_en), .wr_data(wr_data), .irq_wr(irq_wr), .irq_wdata(irq_wdata),
    .clkout_en(clkout_en), .clkout_raw(clkout_raw),
    .irq(irq), .count(count), .clk_out(clk_out));

  always @(posedge clk) begin
    if (clk_out && !pin_d) rises++;
    pin_d <= clk_out;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_flag(input logic v);
    @(negedge clk); irq_wr = 1'b1; irq_wdata = v;
    @(negedge clk); irq_wr = 1'b0;
  endtask

  task automatic sub_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      sub_clk = 1'b1; cycles(8);
      sub_clk = 1'b0; cycles(8);
    end
  endtask

  task automatic iv_delta(input int per, input int m, input int exp, input string req);
    int c0;
    c0 = count;
    cycles(per * m);
    check(8'(count - c0) == 8'(exp), req, 8'(count - c0), exp);
  endtask

  initial begin
    cycles(4);
    // R1: reset state
    check(count == 0 && irq == 0 && clk_out == 0, "R1 reset", count, 0);
    rst = 1'b0;
    cycles(2);

    // R2: sweep all interval taps
    for (int s = 0; s < 8; s++) begin
      wr_ctrl(8'(s));
      cycles(3);
      iv_delta(1 << (s + 1), 3, 3, "R2 interval tap");
    end

    // R3: sweep time-base periods, cleared first
    for (int p = 0; p < 4; p++) begin
      int div;
      div = (p == 0) ? 128 : (p == 1) ? 64 : (p == 2) ? 32 : 4;
      wr_ctrl(8'h0C | 8'(p));
      cycles(4);
      sub_pulses(2 * div);
      cycles(6);
      check(count == 2, "R3 time-base period", count, 2);
    end

    // R4: clear resets counter and sub prescaler (period /4)
    wr_ctrl(8'h0F);
    cycles(4);
    sub_pulses(10);
    cycles(6);
    check(count == 2, "R4 pre-clear count", count, 2);
    wr_ctrl(8'h0F);
    cycles(2);
    check(count == 0, "R4 counter cleared", count, 0);
    sub_pulses(3);
    cycles(6);
    check(count == 0, "R4 prescaler cleared", count, 0);
    sub_pulses(1);
    cycles(6);
    check(count == 1, "R4 first tick after clear", count, 1);

    // R7: standby halts, watch runs (time-base /4)
    pmode = P_STBY; cycles(2);
    begin
      int c0;
      c0 = count;
      sub_pulses(8); cycles(6);
      check(count == c0, "R7 standby halt", count, c0);
      pmode = P_WCH; cycles(2);
      c0 = count;
      sub_pulses(8); cycles(6);
      check(8'(count - c0) == 2, "R7 watch runs", 8'(count - c0), 2);
    end

    // R8: write ignored in watch (would switch to interval)
    wr_ctrl(8'h00);
    begin
      int c0;
      c0 = count;
      cycles(64);
      check(count == c0, "R8 write ignored in watch", count, c0);
    end

    // R8 / R6: interval in active, write ignored in sleep, halts in watch
    pmode = P_ACT;
    wr_ctrl(8'h00);
    pmode = P_SLP;
    wr_ctrl(8'h0F);
    cycles(2);
    iv_delta(2, 32, 32, "R8 write ignored in sleep");
    pmode = P_WCH; cycles(2);
    iv_delta(2, 32, 0, "R6 interval halts in watch");
    pmode = P_SUBS; cycles(2);
    iv_delta(2, 32, 0, "R6 interval halts in subsleep");
    pmode = P_SUBA;
    wr_ctrl(8'h0C);
    cycles(2);
    check(count == 0, "R8 write accepted in subactive", count, 0);

    // R5: overflow flag
    pmode = P_ACT;
    wr_ctrl(8'h00);
    cycles(400);
    check(irq == 0, "R5 no flag before rollover", irq, 0);
    cycles(200);
    check(irq == 1, "R5 flag on rollover", irq, 1);
    wr_flag(1'b1);
    check(irq == 1, "R5 write of 1 ignored", irq, 1);
    wr_flag(1'b0);
    check(irq == 0, "R5 write of 0 clears", irq, 0);

    // R1: reset power mode clears state and control
    wr_ctrl(8'h0F);
    pmode = P_RST; cycles(3);
    check(count == 0 && irq == 0, "R1 reset mode clear", count, 0);
    pmode = P_ACT; cycles(2);
    iv_delta(2, 32, 32, "R1 control cleared");

    // R9: clock output dividers
    clkout_en = 1'b1;
    wr_ctrl(8'h60);                   // system /4
    cycles(8); rises = 0; cycles(64);
    check(rises == 16, "R9 system div4", rises, 16);
    wr_ctrl(8'h00);                   // system /32
    cycles(40); rises = 0; cycles(256);
    check(rises == 8, "R9 system div32", rises, 8);
    wr_ctrl(8'hC0);                   // sub /8
    cycles(8); rises = 0; sub_pulses(32); cycles(8);
    check(rises == 4, "R9 sub div8", rises, 4);
    clkout_raw = 1'b1;
    cycles(4); rises = 0; sub_pulses(10); cycles(8);
    check(rises == 10, "R9 raw subclock", rises, 10);
    clkout_en = 1'b0;
    cycles(4); rises = 0; sub_pulses(6); cycles(8);
    check(rises == 0, "R9 pin disabled", rises, 0);

    // R10: gating by power mode
    clkout_en = 1'b1;
    pmode = P_STBY; cycles(4); rises = 0; sub_pulses(6); cycles(8);
    check(rises == 6, "R10 raw in standby", rises, 6);
    clkout_raw = 1'b0;
    cycles(4); rises = 0; sub_pulses(16); cycles(8);
    check(rises == 0, "R10 sub div in standby", rises, 0);
    pmode = P_WCH;
    wr_ctrl(8'hE0);                   // ignored in watch: stays sub /8
    cycles(4); rises = 0; sub_pulses(16); cycles(8);
    check(rises == 2, "R10 sub div in watch", rises, 2);
    pmode = P_ACT;
    wr_ctrl(8'h60);                   // system /4
    pmode = P_WCH;
    cycles(4); rises = 0; cycles(64);
    check(rises == 0, "R10 system src in watch", rises, 0);

    // R11: one increment per subclock edge (time-base /4, 4 edges -> 1)
    pmode = P_ACT;
    wr_ctrl(8'h0F);
    cycles(4);
    sub_pulses(4); cycles(6);
    check(count == 1, "R11 one pulse per edge", count, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R1 watchdog actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule